// File: doc/BRIEF.md
# Virtual Address Segment Decoder

The decoder takes a 64-bit virtual address and sorts it into one of seven address regions. The regions are tested in a fixed order of ascending upper bounds. The decoder uses the privilege state of the request to decide the outcome. There are three outcomes. The address may need translation by a downstream TLB. It may map straight onto a physical address. Or it is illegal. For a direct mapping the decoder also gives the physical address and grants read and write access.

The request state has four parts. A user-mode flag stops user code from reaching the upper three quarters of the address space. An error-level flag lets user code see the lowest 2 GiB untranslated. Three separate enables open the 64-bit user, supervisor and kernel regions. Each of these regions is also limited to a 40-bit segment size. The result is registered and comes out one clock after the request, together with a valid strobe. Between requests the outputs keep their last values.

Top module: `vaseg_decoder`

## Requirements
- R1: While reset is asserted and after it is released, before any request: `rsp_valid`=0, `rsp_kind`=0, `rsp_paddr`=0, `rsp_rd`=0, `rsp_wr`=0.
- R2: `rsp_valid` equals `req_valid` delayed by exactly one clock. The fields `rsp_kind`, `rsp_paddr`, `rsp_rd` and `rsp_wr` update only in the cycle after a valid request, and hold their values otherwise.
- R3: With `user_mode`=1, any address above 0x3FFF_FFFF_FFFF_FFFF (bit 63 or bit 62 set) gives result 2. This rule takes priority over every other rule.
- R4: An address in 0x0 to 0x7FFF_FFFF gives result 0, unless both `user_mode` and `err_level` are 1. In that case it gives result 1 with physical address = address.
- R5: An address from 0x8000_0000 up to, but not including, 0x3FFF_FFFF_FFFF_FFFF gives result 0 when `ux_en`=1 and the address is below 0xFF_FFFF_FFFF. Otherwise it gives result 2.
- R6: An address from 0x3FFF_FFFF_FFFF_FFFF up to, but not including, 0x7FFF_FFFF_FFFF_FFFF gives result 0 when `sx_en`=1 and the address is below 0x4000_00FF_FFFF_FFFF. Otherwise it gives result 2.
- R7: An address from 0x7FFF_FFFF_FFFF_FFFF up to, but not including, 0xBFFF_FFFF_FFFF_FFFF gives result 1 with physical address = address bits [39:0]. This needs `kx_en`=1 and (address AND 0x03FF_FFFF_FFFF_FFFF) below 0xF_FFFF_FFFF. Otherwise it gives result 2.
- R8: An address from 0xBFFF_FFFF_FFFF_FFFF up to, but not including, 0xFFFF_FFFF_7FFF_FFFF gives result 0 when `kx_en`=1 and the address is below 0xC000_00FF_7FFF_FFFF. Otherwise it gives result 2.
- R9: An address from 0xFFFF_FFFF_7FFF_FFFF through 0xFFFF_FFFF_BFFF_FFFF gives result 1 with physical address = address bits [31:0], zero-extended.
- R10: An address at or above 0xFFFF_FFFF_C000_0000 gives result 0 (unless R3 applies).
- R11: Result encoding on `rsp_kind`: 0 = needs translation, 1 = direct physical, 2 = illegal. `rsp_rd` and `rsp_wr` are 1 exactly when the result is 1. `rsp_paddr` is 0 whenever the result is not 1.
- R12: Every region bound is compared with strict less-than. An address equal to a bound belongs to the next region up. Each address falls in exactly one region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Virtual address |
| user_mode | input | 1 | Request issued in user mode |
| err_level | input | 1 | Error-level state flag |
| ux_en | input | 1 | 64-bit user region enable |
| sx_en | input | 1 | 64-bit supervisor region enable |
| kx_en | input | 1 | 64-bit kernel region enable |
| rsp_valid | output | 1 | Result strobe, one clock after the request |
| rsp_kind | output | 2 | Result code (0 translate, 1 direct, 2 illegal) |
| rsp_paddr | output | 40 | Physical address for a direct result, else 0 |
| rsp_rd | output | 1 | Read permitted (direct result) |
| rsp_wr | output | 1 | Write permitted (direct result) |

## Verification
The user-mode rejection and the error-level pass-through can both apply to one request. When they do, the rejection must win. The bench creates this conflict with `user_mode` and `err_level` both high. It also sets the region enables, both inside and outside the lowest 2 GiB, so that a wrongly ordered rule would let the access through. A second conflict involves the hold rule. A new request can arrive in the cycle right after a result that must be held. Back-to-back and gapped random requests exercise this case, and the behavioural model compares every field on every clock.

// File: rtl/vaseg_pkg.sv
package vaseg_pkg;

  localparam int unsigned VA_W        = 64;
  localparam int unsigned NUM_REGIONS = 7;

  typedef enum logic [1:0] {
    VS_MAP   = 2'd0,
    VS_UNMAP = 2'd1,
    VS_BAD   = 2'd2
  } vs_kind_e;

  // Region indices, in ascending address order
  localparam int unsigned RG_LOW_USER  = 0;
  localparam int unsigned RG_X_USER    = 1;
  localparam int unsigned RG_X_SUPER   = 2;
  localparam int unsigned RG_X_KDIRECT = 3;
  localparam int unsigned RG_X_KMAPPED = 4;
  localparam int unsigned RG_C_DIRECT  = 5;
  localparam int unsigned RG_C_MAPPED  = 6;

  // Exclusive upper bound of region idx (the last region has none)
  function automatic logic [VA_W-1:0] region_bound(input int unsigned idx);
    case (idx)
      0:       return 64'h0000_0000_8000_0000;
      1:       return 64'h3FFF_FFFF_FFFF_FFFF;
      2:       return 64'h7FFF_FFFF_FFFF_FFFF;
      3:       return 64'hBFFF_FFFF_FFFF_FFFF;
      4:       return 64'hFFFF_FFFF_7FFF_FFFF;
      5:       return 64'hFFFF_FFFF_C000_0000;
      default: return '1;
    endcase
  endfunction

endpackage

// File: rtl/vaseg_region_classify.sv
module vaseg_region_classify
  import vaseg_pkg::*;
(
  input  logic [VA_W-1:0]        addr,
  output logic [NUM_REGIONS-1:0] hit
);

  logic [NUM_REGIONS-1:0] below;

  // Bounds rise monotonically, so region i is the first bound passed
  for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_rgn
    if (gi == NUM_REGIONS - 1) begin : g_top
      assign below[gi] = 1'b1;
    end else begin : g_cmp
      assign below[gi] = (addr < region_bound(gi));
    end

    if (gi == 0) begin : g_first
      assign hit[gi] = below[gi];
    end else begin : g_next
      assign hit[gi] = below[gi] & ~below[gi-1];
    end
  end

endmodule

// File: rtl/vaseg_outcome.sv
module vaseg_outcome
  import vaseg_pkg::*;
#(
  parameter int unsigned SEG_BITS = 40,
  parameter int unsigned PA_BITS  = 36,
  parameter int unsigned PA_W     = 40
) (
  input  logic [VA_W-1:0]        addr,
  input  logic [NUM_REGIONS-1:0] hit,
  input  logic                   user_mode,
  input  logic                   err_level,
  input  logic                   ux_en,
  input  logic                   sx_en,
  input  logic                   kx_en,
  output vs_kind_e               kind,
  output logic [PA_W-1:0]        paddr,
  output logic                   perm_rw
);

  localparam logic [VA_W-1:0] SEG_MASK   = (64'd1 << SEG_BITS) - 64'd1;
  localparam logic [VA_W-1:0] USER_TOP   = 64'h3FFF_FFFF_FFFF_FFFF;
  localparam logic [VA_W-1:0] XU_LIMIT   = SEG_MASK;
  localparam logic [VA_W-1:0] XS_LIMIT   = 64'h4000_0000_0000_0000 | SEG_MASK;
  localparam logic [VA_W-1:0] XKM_LIMIT  = (64'hC000_0000_0000_0000 | SEG_MASK)
                                           - 64'h0000_0000_8000_0000;
  localparam logic [VA_W-1:0] XKD_LIMIT  = (64'd1 << PA_BITS) - 64'd1;
  localparam logic [VA_W-1:0] XKD_OFFSET = 64'h03FF_FFFF_FFFF_FFFF;
  localparam int unsigned     PA_PAD     = PA_W - 32;

  vs_kind_e        kind_sel;
  logic [PA_W-1:0] pa_sel;

  always_comb begin
    kind_sel = VS_BAD;
    pa_sel   = '0;
    if (user_mode && (addr > USER_TOP)) begin
      kind_sel = VS_BAD;
    end else if (hit[RG_LOW_USER]) begin
      if (user_mode && err_level) begin
        kind_sel = VS_UNMAP;
        pa_sel   = addr[PA_W-1:0];
      end else begin
        kind_sel = VS_MAP;
      end
    end else if (hit[RG_X_USER]) begin
      kind_sel = (ux_en && (addr < XU_LIMIT)) ? VS_MAP : VS_BAD;
    end else if (hit[RG_X_SUPER]) begin
      kind_sel = (sx_en && (addr < XS_LIMIT)) ? VS_MAP : VS_BAD;
    end else if (hit[RG_X_KDIRECT]) begin
      if (kx_en && ((addr & XKD_OFFSET) < XKD_LIMIT)) begin
        kind_sel = VS_UNMAP;
        pa_sel   = addr[PA_W-1:0];
      end
    end else if (hit[RG_X_KMAPPED]) begin
      kind_sel = (kx_en && (addr < XKM_LIMIT)) ? VS_MAP : VS_BAD;
    end else if (hit[RG_C_DIRECT]) begin
      kind_sel = VS_UNMAP;
      pa_sel   = {{PA_PAD{1'b0}}, addr[31:0]};
    end else if (hit[RG_C_MAPPED]) begin
      kind_sel = VS_MAP;
    end
  end

  assign kind    = kind_sel;
  assign paddr   = (kind_sel == VS_UNMAP) ? pa_sel : '0;
  assign perm_rw = (kind_sel == VS_UNMAP);

endmodule

// File: rtl/vaseg_out_reg.sv
module vaseg_out_reg
  import vaseg_pkg::*;
#(
  parameter int unsigned PA_W = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  vs_kind_e        in_kind,
  input  logic [PA_W-1:0] in_paddr,
  input  logic            in_rw,
  output logic            q_valid,
  output vs_kind_e        q_kind,
  output logic [PA_W-1:0] q_paddr,
  output logic            q_rw
);

  logic            ld_en;
  vs_kind_e        kind_d;
  logic [PA_W-1:0] paddr_d;
  logic            rw_d;

  always_comb begin
    ld_en   = in_valid;
    kind_d  = in_kind;
    paddr_d = in_paddr;
    rw_d    = in_rw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_kind  <= VS_MAP;
      q_paddr <= '0;
      q_rw    <= 1'b0;
    end else begin
      q_valid <= in_valid;
      if (ld_en) begin
        q_kind  <= kind_d;
        q_paddr <= paddr_d;
        q_rw    <= rw_d;
      end
    end
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> q_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !q_valid);
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(q_kind) && $stable(q_paddr) && $stable(q_rw)));

endmodule

// File: rtl/vaseg_decoder.sv
module vaseg_decoder
  import vaseg_pkg::*;
#(
  parameter int unsigned SEG_BITS = 40,
  parameter int unsigned PA_BITS  = 36,
  parameter int unsigned PA_W     = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [63:0]     req_addr,
  input  logic            user_mode,
  input  logic            err_level,
  input  logic            ux_en,
  input  logic            sx_en,
  input  logic            kx_en,
  output logic            rsp_valid,
  output logic [1:0]      rsp_kind,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_rd,
  output logic            rsp_wr
);

  logic [NUM_REGIONS-1:0] region_hit;
  vs_kind_e               dec_kind;
  logic [PA_W-1:0]        dec_paddr;
  logic                   dec_rw;
  vs_kind_e               reg_kind;
  logic                   reg_rw;

  vaseg_region_classify u_classify (
    .addr (req_addr),
    .hit  (region_hit)
  );

  vaseg_outcome #(
    .SEG_BITS (SEG_BITS),
    .PA_BITS  (PA_BITS),
    .PA_W     (PA_W)
  ) u_outcome (
    .addr      (req_addr),
    .hit       (region_hit),
    .user_mode (user_mode),
    .err_level (err_level),
    .ux_en     (ux_en),
    .sx_en     (sx_en),
    .kx_en     (kx_en),
    .kind      (dec_kind),
    .paddr     (dec_paddr),
    .perm_rw   (dec_rw)
  );

  vaseg_out_reg #(
    .PA_W (PA_W)
  ) u_out_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_kind  (dec_kind),
    .in_paddr (dec_paddr),
    .in_rw    (dec_rw),
    .q_valid  (rsp_valid),
    .q_kind   (reg_kind),
    .q_paddr  (rsp_paddr),
    .q_rw     (reg_rw)
  );

  assign rsp_kind = reg_kind;
  assign rsp_rd   = reg_rw;
  assign rsp_wr   = reg_rw;

  // R12
  single_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones(region_hit) == 1));
  // R3
  user_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && user_mode && (req_addr[63:62] != 2'b00)) |=> (rsp_kind == 2'd2));
  // R4
  err_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && user_mode && err_level && (req_addr < 64'h8000_0000))
      |=> ((rsp_kind == 2'd1) && (rsp_paddr == $past(req_addr[PA_W-1:0]))));
  // R10
  compat_mapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !user_mode && (req_addr >= 64'hFFFF_FFFF_C000_0000)) |=> (rsp_kind == 2'd0));
  // R11
  paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_kind != 2'd1) |-> ((rsp_paddr == '0) && !rsp_rd && !rsp_wr));
  // R11
  direct_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_kind == 2'd1) |-> (rsp_rd && rsp_wr));
  // R11
  kind_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_kind != 2'd3);

endmodule

// File: tb/test_vaseg_decoder.sv
module test_vaseg_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        user_mode = 1'b0;
  logic        err_level = 1'b0;
  logic        ux_en = 1'b0;
  logic        sx_en = 1'b0;
  logic        kx_en = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_kind;
  logic [39:0] rsp_paddr;
  logic        rsp_rd;
  logic        rsp_wr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // expected state after the most recent edge
  logic        e_valid = 1'b0;
  logic [1:0]  e_kind  = 2'd0;
  logic [39:0] e_paddr = '0;
  logic        e_rw    = 1'b0;
  string       e_tag   = "R1";

  always #5 clk = ~clk;

  vaseg_decoder i_vaseg_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .user_mode (user_mode),
    .err_level (err_level),
    .ux_en     (ux_en),
    .sx_en     (sx_en),
    .kx_en     (kx_en),
    .rsp_valid (rsp_valid),
    .rsp_kind  (rsp_kind),
    .rsp_paddr (rsp_paddr),
    .rsp_rd    (rsp_rd),
    .rsp_wr    (rsp_wr)
  );

  // Behavioural reference taken from the requirement text
  function automatic void ref_decode(input logic [63:0] a, input logic u, input logic e,
                                     input logic uxe, input logic sxe, input logic kxe,
                                     output logic [1:0] k, output logic [39:0] pa,
                                     output string tag);
    k = 2'd2;
    pa = '0;
    if (u && (a > 64'h3FFF_FFFF_FFFF_FFFF)) begin
      tag = "R3";
    end else if (a <= 64'h7FFF_FFFF) begin
      tag = "R4";
      if (u && e) begin k = 2'd1; pa = a[39:0]; end
      else k = 2'd0;
    end else if (a < 64'h3FFF_FFFF_FFFF_FFFF) begin
      tag = "R5";
      if (uxe && (a < 64'h0000_00FF_FFFF_FFFF)) k = 2'd0;
    end else if (a < 64'h7FFF_FFFF_FFFF_FFFF) begin
      tag = "R6";
      if (sxe && (a < 64'h4000_00FF_FFFF_FFFF)) k = 2'd0;
    end else if (a < 64'hBFFF_FFFF_FFFF_FFFF) begin
      tag = "R7";
      if (kxe && ((a & 64'h03FF_FFFF_FFFF_FFFF) < 64'hF_FFFF_FFFF)) begin
        k = 2'd1; pa = a[39:0];
      end
    end else if (a < 64'hFFFF_FFFF_7FFF_FFFF) begin
      tag = "R8";
      if (kxe && (a < 64'hC000_00FF_7FFF_FFFF)) k = 2'd0;
    end else if (a < 64'hFFFF_FFFF_C000_0000) begin
      tag = "R9";
      k = 2'd1;
      pa = {8'h00, a[31:0]};
    end else begin
      tag = "R10";
      k = 2'd0;
    end
  endfunction

  task automatic cmp(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    cmp(e_valid ? "R2" : (e_tag == "R1" ? "R1" : "R2"), "rsp_valid", 64'(rsp_valid), 64'(e_valid));
    cmp(e_tag, "rsp_kind", 64'(rsp_kind), 64'(e_kind));
    cmp({e_tag, "/R11"}, "rsp_paddr", 64'(rsp_paddr), 64'(e_paddr));
    cmp({e_tag, "/R11"}, "rsp_rd_wr", {62'd0, rsp_rd, rsp_wr}, {62'd0, e_rw, e_rw});
  endtask

  // One clock: check outputs of the previous edge, then drive the next request
  task automatic step(input logic v, input logic [63:0] a, input logic u, input logic e,
                      input logic uxe, input logic sxe, input logic kxe, input string extra);
    logic [1:0]  k;
    logic [39:0] pa;
    string       t;
    @(negedge clk);
    check_outputs();
    req_valid = v; req_addr = a; user_mode = u; err_level = e;
    ux_en = uxe; sx_en = sxe; kx_en = kxe;
    e_valid = v;
    if (v) begin
      ref_decode(a, u, e, uxe, sxe, kxe, k, pa, t);
      e_kind  = k;
      e_paddr = pa;
      e_rw    = (k == 2'd1);
      e_tag   = (extra == "") ? t : {extra, "/", t};
    end else if (e_tag != "R1") begin
      e_tag = "R2";
    end
  endtask

  function automatic logic [63:0] rand_addr();
    logic [63:0] r;
    r = {$urandom, $urandom};
    case ($urandom_range(0, 8))
      0: return {32'h0, r[31:0]};
      1: return {24'h0, r[39:0]};
      2: return {2'b01, 22'h0, r[39:0]};
      3: return {2'b00, 22'h3FFFFF, r[39:0]};
      4: return {2'b10, r[61:36], 4'h0, r[35:0]};
      5: return {2'b11, 22'h0, r[39:0]};
      6: return {32'hFFFF_FFFF, r[31:0]};
      7: return {28'hFFF_FFFF, r[35:0]};
      default: return r;
    endcase
  endfunction

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=200000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_outputs();                       // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    // R1 after release, before any request
    step(1'b0, 64'h0, 0, 0, 0, 0, 0, "");
    step(1'b0, 64'h0, 0, 0, 0, 0, 0, "");
    e_tag = "R2";
    // R4
    step(1, 64'h0000_1234, 0, 0, 1, 1, 1, "");
    step(1, 64'h7FFF_FFFF, 1, 1, 0, 0, 0, "");
    step(1, 64'h7FFF_FFFF, 1, 0, 1, 1, 1, "");
    step(1, 64'h7FFF_FFFF, 0, 1, 0, 0, 0, "");
    // R2 hold after a direct result
    step(1, 64'h0000_0000_0ABC_D000, 1, 1, 0, 0, 0, "");
    step(0, 64'hFFFF_FFFF_C000_0000, 0, 0, 0, 0, 0, "");
    step(0, 64'h0, 1, 0, 0, 0, 0, "");
    // R5 / R12
    step(1, 64'h0000_0000_8000_0000, 0, 0, 1, 0, 0, "R12");
    step(1, 64'h0000_00FF_FFFF_FFFF, 0, 0, 1, 0, 0, "R12");
    step(1, 64'h0000_00FF_FFFF_FFFE, 1, 0, 1, 0, 0, "");
    step(1, 64'h0000_00FF_FFFF_FFFE, 1, 0, 0, 1, 1, "");
    // R6 / R3 ordering
    step(1, 64'h3FFF_FFFF_FFFF_FFFF, 1, 1, 1, 1, 1, "R12");
    step(1, 64'h4000_0000_0000_0000, 1, 1, 1, 1, 1, "");
    step(1, 64'h4000_0000_0000_0000, 0, 0, 0, 1, 0, "");
    step(1, 64'h4000_00FF_FFFF_FFFF, 0, 0, 0, 1, 0, "R12");
    step(1, 64'h4000_0000_0000_1000, 0, 0, 1, 0, 1, "");
    // R7
    step(1, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 1, "R12");
    step(1, 64'h9000_0001_2345_6780, 0, 0, 0, 0, 1, "");
    step(1, 64'h9000_0001_2345_6780, 0, 0, 1, 1, 0, "");
    step(1, 64'h8000_000F_FFFF_FFFF, 0, 0, 0, 0, 1, "R12");
    step(1, 64'h8000_000F_FFFF_FFFE, 0, 0, 0, 0, 1, "");
    // R8
    step(1, 64'hBFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 1, "R12");
    step(1, 64'hC000_00FF_7FFF_FFFF, 0, 0, 0, 0, 1, "R12");
    step(1, 64'hC000_0000_1000_0000, 0, 0, 1, 1, 0, "");
    // R9
    step(1, 64'hFFFF_FFFF_7FFF_FFFF, 0, 0, 0, 0, 0, "R12");
    step(1, 64'hFFFF_FFFF_8000_1000, 0, 1, 0, 0, 0, "");
    step(1, 64'hFFFF_FFFF_BFFF_FFFF, 0, 0, 1, 1, 1, "");
    // R10
    step(1, 64'hFFFF_FFFF_C000_0000, 0, 0, 0, 0, 0, "R12");
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0, "");
    // R3 against error-level pass-through
    step(1, 64'hFFFF_FFFF_8000_0000, 1, 1, 1, 1, 1, "");
    step(1, 64'h8000_0000_0000_0000, 1, 1, 1, 1, 1, "");
    // Random mix, back-to-back and gapped
    for (int n = 0; n < 3000; n++) begin
      step(($urandom_range(0, 3) != 0), rand_addr(),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "");
    end
    step(0, 64'h0, 0, 0, 0, 0, 0, "");
    step(0, 64'h0, 0, 0, 0, 0, 0, "");
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule